// File: doc/BRIEF.md
# Pixel-Position Ordering Interlock

This block is an admission gate that sits between the rasteriser's pixel-shader launch stream and shader dispatch. It covers only invocations that will touch a resource whose accesses must follow primitive order. It keeps a small content-addressed table with the screen coordinate and completion tag of every ordered invocation still in flight. A new ordered invocation at a coordinate already in the table is held at the input until the older one reports completion. Two invocations on the same pixel therefore never run their ordered accesses at the same time, and they run in submission order. This is the per-pixel ordering that fixed-function depth and blend units have always given.

Requests arrive in raster order on a valid/ready handshake. Each carries X, Y, an ordered-access flag and a tag. An accepted request leaves on the downstream handshake in the same cycle, so the gate adds no latency. Completion comes back as a one-cycle retire pulse carrying the tag. The entry it frees is visible to the lookup in that same cycle, so a request waiting on that pixel is admitted at once. Requests without the ordered flag bypass the table completely.

Top module: `pix_order_gate`

## Requirements
- R1: An ordered request (ord flag = 1) whose X and Y both equal a tracked entry is not admitted: req_ready_o and dn_valid_o stay 0 until that entry is retired.
- R2: Admission is strictly in order. A blocked request at the input holds back everything behind it, and the stall lasts for as many cycles as the conflict does.
- R3: An ordered request with no matching entry and a free slot is admitted in the same cycle when dn_ready_i is 1, and its X, Y and tag become a tracked entry.
- R4: When all DEPTH entries are tracked, an ordered request is stalled even if its position is new.
- R5: A request with ord flag = 0 is admitted whenever dn_ready_i is 1, whatever the table holds, and it does not occupy an entry.
- R6: A retire pulse clears the entry holding its tag. A request stalled on that position, or stalled on a full table, is admitted in the same cycle as the pulse.
- R7: A retire pulse whose tag matches no tracked entry has no effect: a request blocked on a tracked position stays blocked.
- R8: Reset empties the table, so after reset every position is free.
- R9: dn_x_o, dn_y_o, dn_ord_o and dn_tag_o equal the request fields. With dn_ready_i at 0 nothing is accepted and nothing is recorded.
- R10: A match needs both coordinates equal. Equal X with a different Y, or the reverse, is not a conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Launch request present |
| req_ready_o | output | 1 | Launch request accepted this cycle |
| req_x_i | input | XW (12) | Pixel X |
| req_y_i | input | YW (12) | Pixel Y |
| req_ord_i | input | 1 | Ordered-access flag |
| req_tag_i | input | TW (4) | Completion tag |
| dn_valid_o | output | 1 | Dispatch request present |
| dn_ready_i | input | 1 | Dispatch can take a request |
| dn_x_o | output | XW (12) | Dispatched X |
| dn_y_o | output | YW (12) | Dispatched Y |
| dn_ord_o | output | 1 | Dispatched ordered flag |
| dn_tag_o | output | TW (4) | Dispatched tag |
| ret_valid_i | input | 1 | Completion pulse |
| ret_tag_i | input | TW (4) | Tag of the completed invocation |

## Verification
The assertions rely on one input rule: a tag is never given to an ordered request while another tracked entry still holds it. Without this rule, a retire could clear two entries, and the occupancy checks would be meaningless. In its random phase the bench raises a new ordered request only while the table has room, and it picks the tag from those the model shows as unused. The request is held unchanged until it is accepted. The directed full-table case reuses a tag only in the cycle that the tag is retired.

// File: rtl/pog_pkg.sv
package pog_pkg;
  typedef enum logic [1:0] {
    ADM_PASS,
    ADM_TRACK,
    ADM_HOLD_HIT,
    ADM_HOLD_FULL
  } adm_e;
endpackage

// File: rtl/pog_free_pick.sv
module pog_free_pick #(
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0] free_i,
  output logic [DEPTH-1:0] pick_o,
  output logic             any_o
);
  // lowest free slot wins
  always_comb begin
    logic found;
    found  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_i[i] && !found) begin
        pick_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign any_o = |free_i;
endmodule

// File: rtl/pog_pos_table.sv
module pog_pos_table #(
  parameter int DEPTH = 16,
  parameter int XW    = 12,
  parameter int YW    = 12,
  parameter int TW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [XW-1:0]    lkp_x_i,
  input  logic [YW-1:0]    lkp_y_i,
  input  logic             alloc_i,
  input  logic [TW-1:0]    alloc_tag_i,
  input  logic             ret_valid_i,
  input  logic [TW-1:0]    ret_tag_i,
  output logic             hit_o,
  output logic             full_o,
  output logic             ret_hit_o,
  output logic [DEPTH-1:0] vld_o
);
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] clr_vec;
  logic [DEPTH-1:0] eff_vld;
  logic [DEPTH-1:0] hit_vec;
  logic [DEPTH-1:0] pick;
  logic             free_any;
  logic [XW-1:0]    x_q   [DEPTH];
  logic [YW-1:0]    y_q   [DEPTH];
  logic [TW-1:0]    tag_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    // retire is seen by the lookup in the same cycle
    assign clr_vec[i] = ret_valid_i && vld_q[i] && (tag_q[i] == ret_tag_i);
    assign eff_vld[i] = vld_q[i] && !clr_vec[i];
    assign hit_vec[i] = eff_vld[i] && (x_q[i] == lkp_x_i) && (y_q[i] == lkp_y_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q[i] <= 1'b0;
      else         vld_q[i] <= eff_vld[i] || (alloc_i && pick[i]);
    end

    always_ff @(posedge clk_i) begin
      if (alloc_i && pick[i]) begin
        x_q[i]   <= lkp_x_i;
        y_q[i]   <= lkp_y_i;
        tag_q[i] <= alloc_tag_i;
      end
    end
  end

  pog_free_pick #(.DEPTH(DEPTH)) u_pick (
    .free_i (~eff_vld),
    .pick_o (pick),
    .any_o  (free_any)
  );

  assign hit_o     = |hit_vec;
  assign full_o    = !free_any;
  assign ret_hit_o = |clr_vec;
  assign vld_o     = vld_q;
endmodule

// File: rtl/pog_admit.sv
module pog_admit
  import pog_pkg::*;
(
  input  logic req_valid_i,
  input  logic req_ord_i,
  input  logic dn_ready_i,
  input  logic hit_i,
  input  logic full_i,
  output logic req_ready_o,
  output logic dn_valid_o,
  output logic alloc_o
);
  adm_e adm;
  logic go;

  always_comb begin
    if (!req_ord_i)  adm = ADM_PASS;
    else if (hit_i)  adm = ADM_HOLD_HIT;
    else if (full_i) adm = ADM_HOLD_FULL;
    else             adm = ADM_TRACK;
  end

  assign go          = (adm == ADM_PASS) || (adm == ADM_TRACK);
  assign req_ready_o = dn_ready_i && go;
  assign dn_valid_o  = req_valid_i && go;
  assign alloc_o     = req_valid_i && dn_ready_i && (adm == ADM_TRACK);
endmodule

// File: rtl/pix_order_gate.sv
module pix_order_gate #(
  parameter int DEPTH = 16,
  parameter int XW    = 12,
  parameter int YW    = 12,
  parameter int TW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [XW-1:0] req_x_i,
  input  logic [YW-1:0] req_y_i,
  input  logic          req_ord_i,
  input  logic [TW-1:0] req_tag_i,
  output logic          dn_valid_o,
  input  logic          dn_ready_i,
  output logic [XW-1:0] dn_x_o,
  output logic [YW-1:0] dn_y_o,
  output logic          dn_ord_o,
  output logic [TW-1:0] dn_tag_o,
  input  logic          ret_valid_i,
  input  logic [TW-1:0] ret_tag_i
);
  logic             tbl_hit;
  logic             tbl_full;
  logic             tbl_ret_hit;
  logic             alloc;
  logic [DEPTH-1:0] tbl_vld;

  pog_pos_table #(.DEPTH(DEPTH), .XW(XW), .YW(YW), .TW(TW)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lkp_x_i     (req_x_i),
    .lkp_y_i     (req_y_i),
    .alloc_i     (alloc),
    .alloc_tag_i (req_tag_i),
    .ret_valid_i (ret_valid_i),
    .ret_tag_i   (ret_tag_i),
    .hit_o       (tbl_hit),
    .full_o      (tbl_full),
    .ret_hit_o   (tbl_ret_hit),
    .vld_o       (tbl_vld)
  );

  pog_admit u_admit (
    .req_valid_i (req_valid_i),
    .req_ord_i   (req_ord_i),
    .dn_ready_i  (dn_ready_i),
    .hit_i       (tbl_hit),
    .full_i      (tbl_full),
    .req_ready_o (req_ready_o),
    .dn_valid_o  (dn_valid_o),
    .alloc_o     (alloc)
  );

  assign dn_x_o   = req_x_i;
  assign dn_y_o   = req_y_i;
  assign dn_ord_o = req_ord_i;
  assign dn_tag_o = req_tag_i;
endmodule

// File: rtl/pog_checker.sv
module pog_checker #(
  parameter int DEPTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_ord_i,
  input logic             dn_valid_o,
  input logic             dn_ready_i,
  input logic             ret_valid_i,
  input logic             tbl_hit,
  input logic             tbl_full,
  input logic             tbl_ret_hit,
  input logic [DEPTH-1:0] tbl_vld
);
  logic ord_acc;
  assign ord_acc = req_valid_i && req_ready_o && req_ord_i;

  p_hit_blocks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ord_i && tbl_hit |-> !dn_valid_o && !req_ready_o);

  p_full_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ord_i && tbl_full |-> !req_ready_o);

  p_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ord_i && dn_ready_i |-> req_ready_o);

  p_need_dn_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> dn_ready_i);

  p_no_growth_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ord_acc |=> $countones(tbl_vld) <= $past($countones(tbl_vld)));

  p_retire_shrinks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && tbl_ret_hit && !ord_acc |=> $countones(tbl_vld) < $past($countones(tbl_vld)));

  p_bogus_retire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tbl_ret_hit && !ord_acc |=> $stable(tbl_vld));
endmodule

bind pix_order_gate pog_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_ord_i   (req_ord_i),
  .dn_valid_o  (dn_valid_o),
  .dn_ready_i  (dn_ready_i),
  .ret_valid_i (ret_valid_i),
  .tbl_hit     (tbl_hit),
  .tbl_full    (tbl_full),
  .tbl_ret_hit (tbl_ret_hit),
  .tbl_vld     (tbl_vld)
);

// File: tb/tb_pix_order_gate.sv
`timescale 1ns/1ps
module tb_pix_order_gate;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [11:0] req_x_i = '0;
  logic [11:0] req_y_i = '0;
  logic        req_ord_i = 1'b0;
  logic [3:0]  req_tag_i = '0;
  logic        dn_valid_o;
  logic        dn_ready_i = 1'b0;
  logic [11:0] dn_x_o;
  logic [11:0] dn_y_o;
  logic        dn_ord_o;
  logic [3:0]  dn_tag_o;
  logic        ret_valid_i = 1'b0;
  logic [3:0]  ret_tag_i = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int qx[$];
  int qy[$];
  int qt[$];

  always #4 clk = ~clk;

  pix_order_gate dut (.*, .clk_i(clk));

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    req_valid_i = 1'b0; ret_valid_i = 1'b0; dn_ready_i = 1'b0;
    qx.delete(); qy.delete(); qt.delete();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // one cycle: drive at negedge, compare against model, then advance model at posedge
  task automatic step(input bit v, input int x, input int y, input bit o, input int t,
                      input bit dr, input bit rv, input int rt, input string rq, output bit acc);
    int ex[$]; int ey[$]; int et[$];
    bit conflict; bit ok; bit exp_rdy; bit exp_dv;
    @(negedge clk);
    req_valid_i = v; req_x_i = 12'(x); req_y_i = 12'(y); req_ord_i = o; req_tag_i = 4'(t);
    dn_ready_i = dr; ret_valid_i = rv; ret_tag_i = 4'(rt);
    #1;
    for (int i = 0; i < qx.size(); i++) begin
      if (!(rv && qt[i] == rt)) begin
        ex.push_back(qx[i]); ey.push_back(qy[i]); et.push_back(qt[i]);
      end
    end
    conflict = 1'b0;
    for (int i = 0; i < ex.size(); i++)
      if (ex[i] == x && ey[i] == y) conflict = 1'b1;
    ok = !o || (!conflict && ex.size() < DEPTH);
    exp_rdy = dr && ok;
    exp_dv  = v && ok;
    chk(req_ready_o == exp_rdy, rq, "req_ready_o", int'(req_ready_o), int'(exp_rdy));
    chk(dn_valid_o == exp_dv, rq, "dn_valid_o", int'(dn_valid_o), int'(exp_dv));
    if (exp_dv) begin
      chk(dn_x_o == 12'(x) && dn_y_o == 12'(y), "R9", "dn_xy", int'({dn_x_o, dn_y_o}), (x << 12) | y);
      chk(dn_ord_o == o && dn_tag_o == 4'(t), "R9", "dn_ord_tag", int'({dn_ord_o, dn_tag_o}), (int'(o) << 4) | t);
    end
    @(posedge clk);
    acc = v && exp_rdy;
    if (acc && o) begin
      ex.push_back(x); ey.push_back(y); et.push_back(t);
    end
    qx = ex; qy = ey; qt = et;
  endtask

  initial begin
    bit a;
    bit pend; int px; int py; bit po; int pt;
    do_reset();
    // R8: empty after reset, nothing pending
    step(0, 0, 0, 0, 0, 1, 0, 0, "R8", a);
    // R3: fresh ordered position admitted and recorded
    step(1, 5, 9, 1, 0, 1, 0, 0, "R3", a);
    // R1/R2: same position blocked over several cycles
    for (int i = 0; i < 3; i++) step(1, 5, 9, 1, 1, 1, 0, 0, "R2", a);
    // R7: retire of an unused tag leaves the block in place
    step(1, 5, 9, 1, 1, 1, 1, 12, "R7", a);
    step(1, 5, 9, 1, 1, 1, 0, 0, "R7", a);
    // R6: retire of tag 0 frees the pixel in the same cycle
    step(1, 5, 9, 1, 1, 1, 1, 0, "R6", a);
    chk(a == 1'b1, "R6", "accepted on retire", int'(a), 1);
    // R10: one coordinate equal only
    step(1, 5, 8, 1, 2, 1, 0, 0, "R10", a);
    step(1, 6, 9, 1, 3, 1, 0, 0, "R10", a);
    // R5: unordered request on a tracked pixel passes
    step(1, 5, 9, 0, 7, 1, 0, 0, "R5", a);
    // R9: no downstream room, nothing recorded
    step(1, 40, 40, 1, 4, 0, 0, 0, "R9", a);
    step(1, 40, 40, 1, 4, 0, 0, 0, "R9", a);
    step(1, 40, 40, 1, 4, 1, 0, 0, "R9", a);
    chk(a == 1'b1, "R9", "accepted once ready", int'(a), 1);
    step(1, 40, 40, 1, 5, 1, 0, 0, "R1", a);
    // R8: reset clears tracked pixels
    do_reset();
    step(1, 5, 9, 1, 1, 1, 0, 0, "R8", a);
    chk(a == 1'b1, "R8", "pixel free after reset", int'(a), 1);
    do_reset();
    // R4: fill all entries
    for (int i = 0; i < DEPTH; i++) step(1, 100 + i, 7, 1, i, 1, 0, 0, "R3", a);
    step(1, 500, 7, 1, 5, 1, 0, 0, "R4", a);
    step(1, 500, 7, 1, 5, 1, 0, 0, "R4", a);
    step(1, 501, 7, 0, 9, 1, 0, 0, "R5", a);
    step(1, 500, 7, 1, 5, 1, 1, 5, "R6", a);
    chk(a == 1'b1, "R6", "full stall released", int'(a), 1);
    step(1, 105, 7, 1, 6, 1, 0, 0, "R6", a);
    do_reset();
    // random phase: small coordinates for frequent conflicts; requester holds while stalled
    pend = 0; px = 0; py = 0; po = 0; pt = 0;
    for (int n = 0; n < 600; n++) begin
      bit rv; int rt; bit dr;
      if (!pend && ($urandom_range(0, 3) != 0)) begin
        po = ($urandom_range(0, 4) != 0);
        if (po && qt.size() >= DEPTH) po = 0;
        px = $urandom_range(0, 3); py = $urandom_range(0, 3);
        pt = 0;
        if (po) begin
          for (int k = 0; k < 16; k++) begin
            bit used; used = 0;
            foreach (qt[j]) if (qt[j] == k) used = 1;
            if (!used) begin pt = k; break; end
          end
        end else pt = $urandom_range(0, 15);
        pend = 1;
      end
      rv = ($urandom_range(0, 2) == 0);
      rt = $urandom_range(0, 15);
      if (rv && qt.size() > 0 && $urandom_range(0, 3) != 0) rt = qt[$urandom_range(0, qt.size() - 1)];
      dr = ($urandom_range(0, 5) != 0);
      step(pend, px, py, po, pt, dr, rv, rt, "R2", a);
      if (a) pend = 0;
    end
    @(negedge clk);
    req_valid_i = 0; ret_valid_i = 0;
    finish_run();
  end
endmodule